// File: doc/BRIEF.md
# Shared Interrupt Line Conditioner

This block takes the raw interrupt request of a serial port and turns it into the value and output-enable for an interrupt pin. When the pin is dedicated, the request is driven as a plain active-high level with the driver always on. When the pin is shared with other devices, a two-bit style code picks one of three signalling styles. These are an active-low level, an active-high level, or a one-clock active-high pulse on each new request. In every shared style the driver turns off while the block has nothing to signal, so the other devices on the line can use it.

Both outputs come from registers. They reflect the inputs sampled on the previous rising clock edge. The share flag and style code are expected to come from configuration registers that return to zero on bus reset.

Top module: `irq_line_cond`

## Requirements
- R1: While reset is asserted and after it is released (before the first clock edge), `irq_pin_val` is 0 and `irq_pin_oe` is 1, and the stored request history is cleared to "low".
- R2: With `share_on` = 0, after each clock edge `irq_pin_oe` is 1 and `irq_pin_val` equals `irq_req` sampled at that edge, whatever `share_style` holds.
- R3: With `share_on` = 1 and `share_style` = 2'b00 (active-low level), a sampled `irq_req` of 1 gives `irq_pin_val` = 0, `irq_pin_oe` = 1, and a sampled 0 gives `irq_pin_val` = 1, `irq_pin_oe` = 0.
- R4: With `share_on` = 1 and `share_style` = 2'b10 (active-high level), a sampled `irq_req` of 1 gives `irq_pin_val` = 1, `irq_pin_oe` = 1, and a sampled 0 gives `irq_pin_val` = 0, `irq_pin_oe` = 0.
- R5: With `share_on` = 1 and `share_style` = 2'b01 (edge), an edge at which `irq_req` is sampled 1 after being sampled 0 at the previous edge gives `irq_pin_val` = 1, `irq_pin_oe` = 1 for exactly one cycle; at all other edges both outputs are 0.
- R6: In edge style, a request held high yields no further pulse until it has been sampled low and then high again.
- R7: With `share_on` = 1 and `share_style` = 2'b11 (the reserved code), the outputs behave exactly as for 2'b00.
- R8: The request history updates on every edge regardless of style. Entering edge style while `irq_req` was already high at the previous edge produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| irq_req | input | 1 | Raw interrupt request from the serial port, active high |
| share_on | input | 1 | 1 when the interrupt pin is shared with other devices |
| share_style | input | 2 | Shared signalling style: 00 low level, 01 high edge, 10 high level, 11 reserved (as 00) |
| irq_pin_val | output | 1 | Value to drive on the interrupt pin |
| irq_pin_oe | output | 1 | Pin driver enable; 0 releases the shared line |

## Verification
The assertions take for granted that `irq_req`, `share_on` and `share_style` are synchronous to `clk`. They must be stable around each rising edge, so the previous sampled value is a valid reference for the edge and level properties. The bench changes every input only on the falling edge. The stimulus switches styles both while a request is idle and while it is held high, to reach the history corner of R8. It also applies the reserved code and toggles the request quickly in edge style. The reference model advances once per rising edge, using the same sampled inputs.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;

  localparam int STYLE_W = 2;

  typedef enum logic [STYLE_W-1:0] {
    CODE_LOW_LVL  = 2'b00,
    CODE_HIGH_EDG = 2'b01,
    CODE_HIGH_LVL = 2'b10,
    CODE_RSVD     = 2'b11
  } share_code_e;

  typedef enum logic [1:0] {
    DRV_PLAIN,
    DRV_LOW_LVL,
    DRV_HIGH_LVL,
    DRV_HIGH_EDG
  } drv_kind_e;

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic rise_o
);

  logic req_hist_q;
  logic req_hist_d;

  always_comb begin
    req_hist_d = req_i;
    rise_o     = req_i & ~req_hist_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_hist_q <= 1'b0;
    else        req_hist_q <= req_hist_d;
  end

  // R6: a rise is never reported on two consecutive edges
  a_r6_no_double_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/irq_style_dec.sv
module irq_style_dec
  import irq_cond_pkg::*;
(
  input  logic                share_i,
  input  logic [STYLE_W-1:0]  code_i,
  output drv_kind_e           kind_o
);

  always_comb begin
    if (!share_i) begin
      kind_o = DRV_PLAIN;
    end else begin
      unique case (share_code_e'(code_i))
        CODE_HIGH_EDG: kind_o = DRV_HIGH_EDG;
        CODE_HIGH_LVL: kind_o = DRV_HIGH_LVL;
        CODE_LOW_LVL,
        CODE_RSVD:     kind_o = DRV_LOW_LVL;  // R7
        default:       kind_o = DRV_LOW_LVL;
      endcase
    end
  end

  always_comb begin
    a_r7_rsvd_as_low: assert (!(share_i && code_i == 2'b11) || kind_o == DRV_LOW_LVL);
  end

endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv
  import irq_cond_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  drv_kind_e kind_i,
  input  logic      req_i,
  input  logic      rise_i,
  output logic      val_o,
  output logic      oe_o
);

  logic val_d, oe_d;
  logic val_q, oe_q;

  always_comb begin
    unique case (kind_i)
      DRV_PLAIN: begin
        val_d = req_i;
        oe_d  = 1'b1;
      end
      DRV_LOW_LVL: begin
        val_d = ~req_i;
        oe_d  = req_i;
      end
      DRV_HIGH_LVL: begin
        val_d = req_i;
        oe_d  = req_i;
      end
      DRV_HIGH_EDG: begin
        val_d = rise_i;
        oe_d  = rise_i;
      end
      default: begin
        val_d = req_i;
        oe_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= 1'b0;
      oe_q  <= 1'b1;
    end else begin
      val_q <= val_d;
      oe_q  <= oe_d;
    end
  end

  assign val_o = val_q;
  assign oe_o  = oe_q;

  // R2: dedicated pin keeps its driver on
  a_r2_plain_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == DRV_PLAIN) |=> oe_o);
  // R3: active-low level drives 0 while requesting
  a_r3_low_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == DRV_LOW_LVL && req_i) |=> (oe_o && !val_o));
  // R4: shared level styles release the line when idle
  a_r4_level_release: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind_i == DRV_HIGH_LVL || kind_i == DRV_LOW_LVL) && !req_i) |=> !oe_o);
  // R5: edge style drives only on a rise, and then drives high
  a_r5_edge_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == DRV_HIGH_EDG) |=> (oe_o == val_o && oe_o == $past(rise_i)));

endmodule

// File: rtl/irq_line_cond.sv
module irq_line_cond
  import irq_cond_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_req,
  input  logic               share_on,
  input  logic [STYLE_W-1:0] share_style,
  output logic               irq_pin_val,
  output logic               irq_pin_oe
);

  logic      rise;
  drv_kind_e kind;

  irq_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (irq_req),
    .rise_o (rise)
  );

  irq_style_dec u_dec (
    .share_i (share_on),
    .code_i  (share_style),
    .kind_o  (kind)
  );

  irq_pin_drv u_drv (
    .clk    (clk),
    .rst_n  (rst_n),
    .kind_i (kind),
    .req_i  (irq_req),
    .rise_i (rise),
    .val_o  (irq_pin_val),
    .oe_o   (irq_pin_oe)
  );

  // R2: dedicated pin follows the request one edge later
  a_r2_plain_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !share_on |=> (irq_pin_val == $past(irq_req)));

endmodule

// File: tb/irq_line_cond_tb.sv
module irq_line_cond_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       irq_req;
  logic       share_on;
  logic [1:0] share_style;
  logic       irq_pin_val;
  logic       irq_pin_oe;

  int checks = 0;
  int errors = 0;
  bit prev_req = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_line_cond dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .share_on    (share_on),
    .share_style (share_style),
    .irq_pin_val (irq_pin_val),
    .irq_pin_oe  (irq_pin_oe)
  );

  task automatic compare(input string tag, input bit ev, input bit eo);
    checks++;
    if (irq_pin_val !== ev || irq_pin_oe !== eo) begin
      errors++;
      $display("FAIL %s: val/oe actual %b/%b expected %b/%b", tag, irq_pin_val, irq_pin_oe, ev, eo);
    end
  endtask

  // drive on the falling edge, let one rising edge pass, then compare
  task automatic step(input string tag, input bit r, input bit sh, input bit [1:0] st);
    bit ev, eo;
    @(negedge clk);
    irq_req = r; share_on = sh; share_style = st;
    @(posedge clk);
    #1;
    if (!sh) begin
      ev = r; eo = 1'b1;
    end else if (st == 2'b01) begin
      ev = r && !prev_req; eo = ev;
    end else if (st == 2'b10) begin
      ev = r; eo = r;
    end else begin
      ev = !r; eo = r;
    end
    prev_req = r;
    compare(tag, ev, eo);
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_req = 1'b0; share_on = 1'b0; share_style = 2'b00;
    repeat (3) @(posedge clk);
    #1 compare("R1 in reset", 1'b0, 1'b1);
    @(negedge clk);
    irq_req = 1'b1; share_on = 1'b1; share_style = 2'b01;
    rst_n = 1'b1;
    #1 compare("R1 after release", 1'b0, 1'b1);
    // first edge after reset: history low, so a pulse
    @(posedge clk);
    #1;
    prev_req = 1'b1;
    compare("R1 history cleared", 1'b1, 1'b1);

    // R2 dedicated pin, style ignored
    step("R2 low", 0, 0, 2'b01);
    step("R2 high", 1, 0, 2'b10);
    step("R2 high style11", 1, 0, 2'b11);
    step("R2 low style00", 0, 0, 2'b00);

    // R3 active-low level
    step("R3 idle", 0, 1, 2'b00);
    step("R3 active", 1, 1, 2'b00);
    step("R3 held", 1, 1, 2'b00);
    step("R3 clear", 0, 1, 2'b00);

    // R4 active-high level
    step("R4 active", 1, 1, 2'b10);
    step("R4 clear", 0, 1, 2'b10);

    // R5 / R6 edge
    step("R5 idle", 0, 1, 2'b01);
    step("R5 rise", 1, 1, 2'b01);
    step("R6 held", 1, 1, 2'b01);
    step("R6 held2", 1, 1, 2'b01);
    step("R5 drop", 0, 1, 2'b01);
    step("R6 rerise", 1, 1, 2'b01);
    step("R5 drop2", 0, 1, 2'b01);
    step("R5 fast rise", 1, 1, 2'b01);

    // R7 reserved code
    step("R7 active", 1, 1, 2'b11);
    step("R7 clear", 0, 1, 2'b11);
    step("R7 active2", 1, 1, 2'b11);

    // R8 enter edge style while request already high
    step("R8 enter edge high", 1, 1, 2'b01);
    step("R8 unshared high", 1, 0, 2'b00);
    step("R8 edge still high", 1, 1, 2'b01);
    step("R8 low", 0, 1, 2'b10);
    step("R8 rise in edge", 1, 1, 2'b01);

    // mixed sweep
    for (int i = 0; i < 64; i++) begin
      step("R2-sweep", bit'((i * 7 + 3) % 5 < 2), bit'(i % 3 != 0), 2'(i / 3));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule